// File: doc/BRIEF.md
# Dual-Channel DAC Register Front-End with Two-Wire Slave

This block is the digital side of a two-channel voltage DAC. A two-wire (I2C-compatible) slave port receives a write transaction: one slave-address byte followed by data bytes grouped in frames of three. Each frame carries a command, a channel selector and a code. Every channel has two registers in series. The input register holds a staged code. The DAC register holds the code that the converter actually sees.

A code moves from the input register to the DAC register in one of two ways: by a command in a frame, or by an active-low update pin that works independently of the serial clock. Three address pins, each with three possible levels, select one of 27 slave addresses. A parameter picks the power-on code, zero scale or midscale, and another picks the code width (12, 14 or 16 bits).

The serial lines are sampled by the system clock, which must run much faster than SCL. The block supports standard mode (100 kHz) and fast mode (400 kHz).

Top module: `dual_dac_front`

## Requirements
- R1: After reset, both input registers and both DAC registers hold the power-on code: 0 when RST_MID is 0, and 2^(W-1) when RST_MID is 1. Both power-down flags are low and sda_oe is low.
- R2: Each 2-bit address-pin code maps to a level value: 00 is 0, 10 is 2, and 01 or 11 is 1. The slave address is BASE_ADDR + 9*lvl(addr_pins[5:4]) + 3*lvl(addr_pins[3:2]) + lvl(addr_pins[1:0]), with BASE_ADDR defaulting to 7'h10.
- R3: The block acknowledges an address byte that matches its slave address and has bit 0 (read/write) equal to 0. It also acknowledges every data byte that follows. To acknowledge, it raises sda_oe while SCL is low after the 8th bit, and releases it at the falling edge of the 9th clock. If the address does not match, or the read bit is set, the block gives no acknowledge and ignores the bus until the next START.
- R4: In the first byte of a frame, bits 7:4 are the command and bits 3:0 select the channel: 0 is A, 1 is B, F is both. Any other channel value has no effect. The next two bytes form a 16-bit word, sent MSB first. The code is the top W bits of that word, so the low bits are ignored when W is less than 16.
- R5: A frame takes effect at the falling edge of the 9th clock of its third byte. A STOP or a repeated START before that point discards the partial frame. The DAC outputs change only when a frame takes effect or the update pin is low.
- R6: Command 0 writes the input register only. Command 1 copies the input register into the DAC register. Command 3 writes both registers with the code. Any other command, except 4, has no effect.
- R7: While the synchronized ldac_n is low, the block copies both input registers into both DAC registers on every clock. ldac_n must stay low for at least two clocks.
- R8: Command 4 sets the power-down flag of each selected channel and leaves its codes unchanged. Any load into a channel's DAC register, whether by command 1, command 3 or the update pin, clears that channel's flag.
- R9: Inside one write transaction, data bytes are grouped in threes. Each completed group is applied as its own frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial lines |
| rst_n | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line (as seen on the bus) |
| sda_oe | output | 1 | 1 = pull SDA low (acknowledge) |
| addr_pins | input | 6 | Three 2-bit address-pin level codes, pin 2 in bits 5:4 |
| ldac_n | input | 1 | Asynchronous active-low DAC update |
| dac_a | output | W | Channel A DAC register code |
| dac_b | output | W | Channel B DAC register code |
| pd_a | output | 1 | Channel A power-down flag |
| pd_b | output | 1 | Channel B power-down flag |

## Verification
The hardest cases to reach are frames that are cut short. A STOP or repeated START must arrive after some data bytes but before the falling edge that commits the frame, and the stale partial bytes must never leak into a later frame. The bench drives these cases with its own bit-level bus tasks. It stops after two data bytes and reads the unchanged outputs. It then issues a repeated START in the same position and follows it with a full frame, and it also sends six data bytes in one transaction to show two separate commits. A second instance, built with 12-bit codes and midscale reset, shares the bus, so the same frames show the left-justified truncation.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
   typedef enum logic [3:0] {
      CMD_WR_IN  = 4'h0,
      CMD_UPD    = 4'h1,
      CMD_WR_UPD = 4'h3,
      CMD_PWRDN  = 4'h4
   } dac_cmd_e;

   localparam logic [3:0] SEL_A    = 4'h0;
   localparam logic [3:0] SEL_B    = 4'h1;
   localparam logic [3:0] SEL_BOTH = 4'hF;
   localparam int         NCH      = 2;
   localparam int         FRAME_W  = 24;

   // level value of one three-state address pin
   function automatic int pin_level(input logic [1:0] code);
      case (code)
         2'b00:   return 0;
         2'b10:   return 2;
         default: return 1;
      endcase
   endfunction
endpackage

// File: rtl/dacfe_addr.sv
module dacfe_addr
   import dacfe_pkg::*;
#(
   parameter logic [6:0] BASE = 7'h10
) (
   input  logic [5:0] pins,
   output logic [6:0] addr
);
   localparam int NUM_ADDR = 27;

   logic [6:0] addr_tbl [NUM_ADDR];
   logic [4:0] idx;

   for (genvar i = 0; i < NUM_ADDR; i++) begin : g_tbl
      assign addr_tbl[i] = BASE + 7'(i);
   end

   assign idx  = 5'(9 * pin_level(pins[5:4]) + 3 * pin_level(pins[3:2]) + pin_level(pins[1:0]));
   assign addr = addr_tbl[idx];
endmodule

// File: rtl/dacfe_i2c_rx.sv
module dacfe_i2c_rx
   import dacfe_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic [6:0]         own_addr,
   output logic               sda_oe,
   output logic               scl_s,
   output logic               stb,
   output logic [FRAME_W-1:0] frame
);
   typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_SKIP} rx_state_e;

   logic [2:0] scl_p, sda_p;
   logic       scl_rise, scl_fall, bus_start, bus_stop;
   rx_state_e  st;
   logic [7:0] shreg;
   logic [3:0] bcnt;
   logic [1:0] dcnt;
   logic       in_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= '1;
         sda_p <= '1;
      end else begin
         scl_p <= {scl_p[1:0], scl_i};
         sda_p <= {sda_p[1:0], sda_i};
      end
   end

   assign scl_s     = scl_p[1];
   assign scl_rise  = scl_p[1] & ~scl_p[2];
   assign scl_fall  = ~scl_p[1] & scl_p[2];
   assign bus_start = scl_p[1] & scl_p[2] & ~sda_p[1] & sda_p[2];
   assign bus_stop  = scl_p[1] & scl_p[2] & sda_p[1] & ~sda_p[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         shreg  <= '0;
         bcnt   <= '0;
         dcnt   <= '0;
         in_ack <= 1'b0;
         sda_oe <= 1'b0;
         stb    <= 1'b0;
         frame  <= '0;
      end else begin
         stb <= 1'b0;
         if (bus_start) begin
            st     <= S_ADDR;
            bcnt   <= '0;
            dcnt   <= '0;
            in_ack <= 1'b0;
            sda_oe <= 1'b0;
         end else if (bus_stop) begin
            st     <= S_IDLE;
            in_ack <= 1'b0;
            sda_oe <= 1'b0;
         end else if (st == S_ADDR || st == S_DATA) begin
            if (scl_rise && bcnt != 4'd8) begin
               shreg <= {shreg[6:0], sda_p[1]};
               bcnt  <= bcnt + 4'd1;
            end else if (scl_fall) begin
               if (in_ack) begin
                  in_ack <= 1'b0;
                  sda_oe <= 1'b0;
                  bcnt   <= '0;
                  if (st == S_ADDR) begin
                     st <= S_DATA;
                  end else if (dcnt == 2'd2) begin
                     stb  <= 1'b1;
                     dcnt <= '0;
                  end else begin
                     dcnt <= dcnt + 2'd1;
                  end
               end else if (bcnt == 4'd8) begin
                  if (st == S_ADDR) begin
                     if (shreg == {own_addr, 1'b0}) begin
                        sda_oe <= 1'b1;
                        in_ack <= 1'b1;
                     end else begin
                        st <= S_SKIP;
                     end
                  end else begin
                     sda_oe <= 1'b1;
                     in_ack <= 1'b1;
                     case (dcnt)
                        2'd0:    frame[23:16] <= shreg;
                        2'd1:    frame[15:8]  <= shreg;
                        default: frame[7:0]   <= shreg;
                     endcase
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs
   import dacfe_pkg::*;
#(
   parameter int W       = 16,
   parameter bit RST_MID = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    stb,
   input  logic [FRAME_W-1:0]      frame,
   input  logic                    upd,
   output logic [NCH-1:0][W-1:0]   inp_o,
   output logic [NCH-1:0][W-1:0]   dac_o,
   output logic [NCH-1:0]          pd_o
);
   localparam logic [W-1:0] RST_CODE = RST_MID ? {1'b1, {(W-1){1'b0}}} : '0;

   logic [3:0]   cmd, sel;
   logic [W-1:0] code;

   assign cmd  = frame[23:20];
   assign sel  = frame[19:16];
   assign code = frame[15 -: W];

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic [W-1:0] inp_r, dac_r;
      logic         pd_r, hit;

      assign hit = stb && (sel == 4'(ch) || sel == SEL_BOTH);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            inp_r <= RST_CODE;
            dac_r <= RST_CODE;
            pd_r  <= 1'b0;
         end else begin
            if (upd) begin
               dac_r <= inp_r;
               pd_r  <= 1'b0;
            end
            if (hit) begin
               case (cmd)
                  CMD_WR_IN: inp_r <= code;
                  CMD_UPD: begin
                     dac_r <= inp_r;
                     pd_r  <= 1'b0;
                  end
                  CMD_WR_UPD: begin
                     inp_r <= code;
                     dac_r <= code;
                     pd_r  <= 1'b0;
                  end
                  CMD_PWRDN: pd_r <= 1'b1;
                  default: ;
               endcase
            end
         end
      end

      assign inp_o[ch] = inp_r;
      assign dac_o[ch] = dac_r;
      assign pd_o[ch]  = pd_r;
   end
endmodule

// File: rtl/dual_dac_front.sv
module dual_dac_front
   import dacfe_pkg::*;
#(
   parameter int         W         = 16,
   parameter bit         RST_MID   = 1'b0,
   parameter logic [6:0] BASE_ADDR = 7'h10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         scl_i,
   input  logic         sda_i,
   output logic         sda_oe,
   input  logic [5:0]   addr_pins,
   input  logic         ldac_n,
   output logic [W-1:0] dac_a,
   output logic [W-1:0] dac_b,
   output logic         pd_a,
   output logic         pd_b
);
   if (W != 12 && W != 14 && W != 16) begin : g_bad_width
      $error("dual_dac_front: W must be 12, 14 or 16");
   end

   logic [6:0]               own_addr;
   logic                     scl_s, frame_stb;
   logic [FRAME_W-1:0]       frame;
   logic [1:0]               ldac_s;
   logic [NCH-1:0][W-1:0]    inp_q, dac_q;
   logic [NCH-1:0]           pd_q;

   dacfe_addr #(.BASE(BASE_ADDR)) u_addr (
      .pins (addr_pins),
      .addr (own_addr)
   );

   dacfe_i2c_rx u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .own_addr (own_addr),
      .sda_oe   (sda_oe),
      .scl_s    (scl_s),
      .stb      (frame_stb),
      .frame    (frame)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ldac_s <= 2'b11;
      else        ldac_s <= {ldac_s[0], ldac_n};
   end

   dacfe_regs #(.W(W), .RST_MID(RST_MID)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .stb   (frame_stb),
      .frame (frame),
      .upd   (~ldac_s[1]),
      .inp_o (inp_q),
      .dac_o (dac_q),
      .pd_o  (pd_q)
   );

   assign dac_a = dac_q[0];
   assign dac_b = dac_q[1];
   assign pd_a  = pd_q[0];
   assign pd_b  = pd_q[1];
endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         stb,
   input logic         upd_n,
   input logic         scl_s,
   input logic         sda_oe,
   input logic [W-1:0] dac_a,
   input logic [W-1:0] dac_b,
   input logic [W-1:0] inp_a,
   input logic [W-1:0] inp_b
);
   // R5: outputs move only on a commit or the update pin
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!stb && upd_n) |=> ($stable(dac_a) && $stable(dac_b)));

   // R7: update pin copies both staged codes
   p_pin_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!stb && !upd_n) |=> (dac_a == $past(inp_a) && dac_b == $past(inp_b)));

   // R3: acknowledge starts only while SCL is low
   p_ack_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);

   // R5: a frame commits only after the acknowledge is released
   p_commit_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stb |-> !sda_oe);
endmodule

bind dual_dac_front dacfe_chk #(.W(W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .stb    (frame_stb),
   .upd_n  (ldac_s[1]),
   .scl_s  (scl_s),
   .sda_oe (sda_oe),
   .dac_a  (dac_a),
   .dac_b  (dac_b),
   .inp_a  (inp_q[0]),
   .inp_b  (inp_q[1])
);

// File: tb/dual_dac_front_tb_top.sv
module dual_dac_front_tb_top;
   localparam int Q = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        sda_m = 1'b1;
   logic [5:0]  addr_pins = 6'b010101;
   logic        ldac_n = 1'b1;
   logic        oe0, oe1, pd_a, pd_b, pd_a12, pd_b12;
   logic [15:0] dac_a, dac_b;
   logic [11:0] dac_a12, dac_b12;
   wire         sda_line = sda_m & ~oe0 & ~oe1;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dual_dac_front dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(oe0),
      .addr_pins(addr_pins), .ldac_n(ldac_n), .dac_a(dac_a), .dac_b(dac_b),
      .pd_a(pd_a), .pd_b(pd_b)
   );

   dual_dac_front #(.W(12), .RST_MID(1'b1)) dut12_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(oe1),
      .addr_pins(addr_pins), .ldac_n(ldac_n), .dac_a(dac_a12), .dac_b(dac_b12),
      .pd_a(pd_a12), .pd_b(pd_b12)
   );

   // cmd/chan, code, expected dac_a, expected dac_b
   localparam int NV = 10;
   localparam logic [55:0] VEC [NV] = '{
      {8'h00, 16'h1234, 16'h0000, 16'h0000},
      {8'h01, 16'hABCD, 16'h0000, 16'h0000},
      {8'h1F, 16'h0000, 16'h1234, 16'hABCD},
      {8'h30, 16'hFFFF, 16'hFFFF, 16'hABCD},
      {8'h31, 16'h0001, 16'hFFFF, 16'h0001},
      {8'h3F, 16'h8000, 16'h8000, 16'h8000},
      {8'h72, 16'h5555, 16'h8000, 16'h8000},
      {8'h35, 16'h1111, 16'h8000, 16'h8000},
      {8'h0F, 16'h4321, 16'h8000, 16'h8000},
      {8'h10, 16'h0000, 16'h4321, 16'h8000}
   };

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_cyc(Q);
      scl = 1'b1;   wait_cyc(Q);
      sda_m = 1'b0; wait_cyc(Q);
      scl = 1'b0;   wait_cyc(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_cyc(Q);
      scl = 1'b1;   wait_cyc(Q);
      sda_m = 1'b1; wait_cyc(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wait_cyc(Q);
         scl = 1'b1;   wait_cyc(2 * Q);
         scl = 1'b0;   wait_cyc(Q);
      end
      sda_m = 1'b1; wait_cyc(Q);
      scl = 1'b1;   wait_cyc(Q);
      ack = ~sda_line;
      wait_cyc(Q);
      scl = 1'b0;   wait_cyc(Q);
   endtask

   task automatic send_frame(input logic [6:0] a, input logic [7:0] c, input logic [15:0] d,
                             output logic ack_all);
      logic k0, k1, k2, k3;
      bus_start();
      send_byte({a, 1'b0}, k0);
      send_byte(c, k1);
      send_byte(d[15:8], k2);
      send_byte(d[7:0], k3);
      bus_stop();
      wait_cyc(4);
      ack_all = k0 & k1 & k2 & k3;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R5 watchdog actual=timeout expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic ak, k;
      wait_cyc(5);
      // R1 reset state
      chk("R1 dac_a reset", 32'(dac_a), 32'h0);
      chk("R1 dac_b reset", 32'(dac_b), 32'h0);
      chk("R1 pd/oe reset", {29'b0, pd_a, pd_b, oe0}, 32'h0);
      chk("R1 midscale 12-bit reset", 32'(dac_a12), 32'h800);
      rst_n = 1'b1;
      wait_cyc(5);

      // R6 R4 table walk, address 0x1D (all pins floating, R2)
      for (int i = 0; i < NV; i++) begin
         send_frame(7'h1D, VEC[i][55:48], VEC[i][47:32], ak);
         chk("R3 frame acknowledged", 32'(ak), 32'h1);
         chk("R6 table dac_a", 32'(dac_a), 32'(VEC[i][31:16]));
         chk("R6 table dac_b", 32'(dac_b), 32'(VEC[i][15:0]));
      end

      // R4 left justification on 12-bit instance
      send_frame(7'h1D, 8'h3F, 16'hF00F, ak);
      chk("R4 16-bit code", 32'(dac_a), 32'hF00F);
      chk("R4 12-bit top bits", 32'(dac_b12), 32'hF00);

      // R3 wrong address and read request
      send_frame(7'h1E, 8'h30, 16'h7777, ak);
      chk("R3 wrong address nack", 32'(ak), 32'h0);
      chk("R3 wrong address ignored", 32'(dac_a), 32'hF00F);
      bus_start();
      send_byte({7'h1D, 1'b1}, k);
      bus_stop();
      chk("R3 read request nack", 32'(k), 32'h0);

      // R5 STOP before third data byte
      bus_start();
      send_byte({7'h1D, 1'b0}, k);
      send_byte(8'h30, k);
      send_byte(8'h12, k);
      bus_stop();
      wait_cyc(4);
      chk("R5 partial frame discarded", 32'(dac_a), 32'hF00F);
      // R5 repeated START mid-frame then full frame
      bus_start();
      send_byte({7'h1D, 1'b0}, k);
      send_byte(8'h31, k);
      send_byte(8'h99, k);
      bus_start();
      send_byte({7'h1D, 1'b0}, k);
      send_byte(8'h30, k);
      send_byte(8'h22, k);
      chk("R5 no change before last byte", 32'(dac_a), 32'hF00F);
      send_byte(8'h22, k);
      wait_cyc(4);
      chk("R5 commit at 9th clock", 32'(dac_a), 32'h2222);
      chk("R5 aborted frame left B", 32'(dac_b), 32'hF00F);
      bus_stop();

      // R7 update pin
      send_frame(7'h1D, 8'h00, 16'h0AAA, ak);
      send_frame(7'h1D, 8'h01, 16'h0BBB, ak);
      chk("R7 staged not visible", 32'(dac_a), 32'h2222);
      ldac_n = 1'b0; wait_cyc(4);
      ldac_n = 1'b1; wait_cyc(4);
      chk("R7 pin loads A", 32'(dac_a), 32'h0AAA);
      chk("R7 pin loads B", 32'(dac_b), 32'h0BBB);

      // R8 power down
      send_frame(7'h1D, 8'h40, 16'h0000, ak);
      chk("R8 pd_a set", {30'b0, pd_a, pd_b}, 32'h2);
      chk("R8 code kept", 32'(dac_a), 32'h0AAA);
      send_frame(7'h1D, 8'h10, 16'h0000, ak);
      chk("R8 update clears pd_a", 32'(pd_a), 32'h0);

      // R9 two frames in one transaction
      bus_start();
      send_byte({7'h1D, 1'b0}, k);
      send_byte(8'h30, k); send_byte(8'h01, k); send_byte(8'h01, k);
      send_byte(8'h31, k); send_byte(8'h02, k); send_byte(8'h02, k);
      bus_stop();
      wait_cyc(4);
      chk("R9 first frame", 32'(dac_a), 32'h0101);
      chk("R9 second frame", 32'(dac_b), 32'h0202);

      // R2 address pins: {10,01,00} -> 0x10+21 = 0x25
      addr_pins = 6'b100100;
      wait_cyc(4);
      send_frame(7'h1D, 8'h30, 16'h3333, ak);
      chk("R2 old address rejected", 32'(ak), 32'h0);
      send_frame(7'h25, 8'h30, 16'h3333, ak);
      chk("R2 new address acked", 32'(ak), 32'h1);
      chk("R2 new address write", 32'(dac_a), 32'h3333);
      // code 11 counts as floating: {11,11,11} -> 0x1D
      addr_pins = 6'b111111;
      wait_cyc(4);
      send_frame(7'h1D, 8'h31, 16'h4444, ak);
      chk("R2 code 11 as float", 32'(dac_b), 32'h4444);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule